// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block is the digital mode controller for a single buck converter channel. Each cycle it decides whether the channel runs at fixed-frequency pulse-width modulation (PWM) or in pulse-frequency mode (PFM). In PFM it also drives the high-side switch request directly. It acts on a few comparator flags from the analog side and on a two-bit override field from a control register.

In automatic operation the channel starts in PWM. It moves to PFM only after a light-load indication has held without a break for a qualification window of `QUAL_CYCLES` clocks. There are two light-load flags: the inductor valley current has gone negative, or the peak switch current is below the mode threshold. Either flag counts. The channel returns to PWM as soon as the low-output flag reports a heavy load. The override field can pin the channel in either mode. When PFM is pinned, a reduced switch-current-limit indication is also raised for the power stage.

While the channel is in PFM, the high-side request turns on whenever the output sits below the upper PFM threshold. It then stays on until the output crosses that threshold or the peak current exceeds the PFM current limit. In PWM the request is held low, because PWM gating belongs to other logic.

Top module: `bmode_sel`

## Requirements
- R1: The override field `force_i` holds the PFM-force bit at bit 1 and the PWM-force bit at bit 0. Code 2'b10 pins PFM and 2'b01 pins PWM. Codes 2'b00 and 2'b11 both select automatic operation. The value sampled at a clock edge sets the mode shown after that edge.
- R2: In automatic operation from PWM, `mode_pfm_o` rises after the edge at which `valley_neg_i` or `peak_low_i` (either one) has been sampled high at `QUAL_CYCLES` consecutive edges (32 by default). It is still low after `QUAL_CYCLES`-1 such edges.
- R3: An edge at which both light-load flags are low clears the qualification run. A fresh run of `QUAL_CYCLES` edges is then needed.
- R4: An edge at which `force_i` differs from its value at the previous edge restarts the qualification run, even between the two automatic codes. That edge itself does not count toward the run.
- R5: In automatic operation in PFM, an edge with `vout_low_i` high returns the channel to PWM after that edge.
- R6: While the channel is in PFM and the request is off, an edge with `vout_high_i` low sets `hs_req_o`. The request rises no earlier than the edge after PFM is entered.
- R7: Once `hs_req_o` is high in PFM, it stays high until an edge that samples `vout_high_i` or `peak_over_i` high. After that edge it is low.
- R8: `hs_req_o` is low whenever `mode_pfm_o` is low, including right after the edge that leaves PFM.
- R9: `ilim_reduced_o` is high after an edge exactly when that edge sampled `force_i` = 2'b10.
- R10: During and right after reset, `mode_pfm_o`, `hs_req_o` and `ilim_reduced_o` are low, and the previous override value is taken as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_i | input | 2 | Override field: bit 1 PFM force, bit 0 PWM force |
| valley_neg_i | input | 1 | Inductor valley current below zero |
| peak_low_i | input | 1 | Peak switch current below the mode threshold |
| vout_high_i | input | 1 | Output above the upper PFM threshold |
| peak_over_i | input | 1 | Peak current above the PFM current limit |
| vout_low_i | input | 1 | Output below the low threshold (heavy load) |
| mode_pfm_o | output | 1 | Current mode: 1 = PFM, 0 = PWM |
| hs_req_o | output | 1 | High-side switch request in PFM |
| ilim_reduced_o | output | 1 | Reduced switch-current limit requested (pinned PFM) |

## Verification
Two functions can act in the same edge. An override change can coincide with a qualification run that is about to complete, and the PFM exit can coincide with a live high-side request. The bench sets up the first case by switching between the two automatic codes in the middle of a light-load run. It then checks that entry comes only a full window later. For the second case, the bench raises the low-output flag while the request is on, and checks that the mode and the request both drop after the same edge.

// File: rtl/bmode_pkg.sv
package bmode_pkg;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_PFM = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        SEL_AUTO = 2'd0,
        SEL_PFM  = 2'd1,
        SEL_PWM  = 2'd2
    } sel_e;

    typedef struct packed {
        mode_e      mode;
        logic [1:0] force_raw;
        logic       lim;
    } sel_state_t;

endpackage

// File: rtl/bmode_force_dec.sv
module bmode_force_dec
    import bmode_pkg::*;
(
    input  logic [1:0] force_i,
    output sel_e       sel_o
);

    localparam int PFM_BIT = 1;
    localparam int PWM_BIT = 0;

    always_comb begin
        if (force_i[PFM_BIT] && !force_i[PWM_BIT]) begin
            sel_o = SEL_PFM;
        end else if (!force_i[PFM_BIT] && force_i[PWM_BIT]) begin
            sel_o = SEL_PWM;
        end else begin
            sel_o = SEL_AUTO;
        end
    end

endmodule

// File: rtl/bmode_qual_cnt.sv
module bmode_qual_cnt #(
    parameter int QUAL_CYCLES = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic light_i,
    input  logic restart_i,
    output logic hit_o
);

    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_CYCLES);
    localparam logic [CW-1:0] CNT_HIT = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i || !light_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_o = light_i && (cnt_q >= CNT_HIT);

endmodule

// File: rtl/bmode_pfm_gate.sv
module bmode_pfm_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic vout_high_i,
    input  logic peak_over_i,
    output logic hs_o
);

    logic hs_d, hs_q;

    always_comb begin
        hs_d = 1'b0;
        if (run_i) begin
            if (hs_q) begin
                hs_d = !(vout_high_i || peak_over_i);
            end else begin
                hs_d = !vout_high_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hs_o = hs_q;

endmodule

// File: rtl/bmode_sel.sv
module bmode_sel
    import bmode_pkg::*;
#(
    parameter int QUAL_CYCLES = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] force_i,
    input  logic       valley_neg_i,
    input  logic       peak_low_i,
    input  logic       vout_high_i,
    input  logic       peak_over_i,
    input  logic       vout_low_i,
    output logic       mode_pfm_o,
    output logic       hs_req_o,
    output logic       ilim_reduced_o
);

    sel_state_t st_d, st_q;
    sel_e       sel;
    logic       light;
    logic       force_chg;
    logic       qual_hit;
    logic       leave_pfm;
    logic       restart;
    logic       gate_run;

    bmode_force_dec u_dec (
        .force_i (force_i),
        .sel_o   (sel)
    );

    bmode_qual_cnt #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .light_i   (light),
        .restart_i (restart),
        .hit_o     (qual_hit)
    );

    bmode_pfm_gate u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (gate_run),
        .vout_high_i (vout_high_i),
        .peak_over_i (peak_over_i),
        .hs_o        (hs_req_o)
    );

    always_comb begin
        light     = valley_neg_i || peak_low_i;
        force_chg = (force_i != st_q.force_raw);

        st_d           = st_q;
        st_d.force_raw = force_i;
        st_d.lim       = (sel == SEL_PFM);

        unique case (sel)
            SEL_PFM: st_d.mode = MODE_PFM;
            SEL_PWM: st_d.mode = MODE_PWM;
            default: begin
                if (st_q.mode == MODE_PWM) begin
                    if (qual_hit && !force_chg) begin
                        st_d.mode = MODE_PFM;
                    end
                end else if (vout_low_i) begin
                    st_d.mode = MODE_PWM;
                end
            end
        endcase

        leave_pfm = (st_q.mode == MODE_PFM) && (st_d.mode == MODE_PWM);
        restart   = force_chg || leave_pfm;
        gate_run  = (st_q.mode == MODE_PFM) && (st_d.mode == MODE_PFM);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_PWM, force_raw: 2'b00, lim: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_pfm_o     = (st_q.mode == MODE_PFM);
    assign ilim_reduced_o = st_q.lim;

endmodule

// File: rtl/bmode_sel_chk.sv
module bmode_sel_chk #(
    parameter int QUAL_CYCLES = 32
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] force_i,
    input logic       valley_neg_i,
    input logic       peak_low_i,
    input logic       vout_high_i,
    input logic       peak_over_i,
    input logic       vout_low_i,
    input logic       mode_pfm_o,
    input logic       hs_req_o,
    input logic       ilim_reduced_o
);

    localparam int RW = $clog2(QUAL_CYCLES + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(QUAL_CYCLES);

    logic [RW-1:0] run_q;
    logic [1:0]    fprev_q;
    logic          auto_now;

    assign auto_now = (force_i == 2'b00) || (force_i == 2'b11);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q   <= '0;
            fprev_q <= 2'b00;
        end else begin
            fprev_q <= force_i;
            if ((force_i != fprev_q) || !(valley_neg_i || peak_low_i)) begin
                run_q <= '0;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_FORCE_PFM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i == 2'b10 |=> mode_pfm_o && ilim_reduced_o);  // R1
    AST_FORCE_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i == 2'b01 |=> !mode_pfm_o && !ilim_reduced_o);  // R9
    AST_QUAL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mode_pfm_o) && ($past(force_i) == 2'b00 || $past(force_i) == 2'b11)
        |-> run_q >= RUN_MAX);  // R2
    AST_HEAVY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_pfm_o && auto_now && vout_low_i |=> !mode_pfm_o);  // R5
    AST_HS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_req_o && force_i == 2'b10 && !vout_high_i && !peak_over_i |=> hs_req_o);  // R7
    AST_HS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_req_o && (vout_high_i || peak_over_i) |=> !hs_req_o);  // R7
    AST_HS_PWM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_pfm_o |-> !hs_req_o);  // R8

endmodule

bind bmode_sel bmode_sel_chk #(
    .QUAL_CYCLES (QUAL_CYCLES)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .force_i        (force_i),
    .valley_neg_i   (valley_neg_i),
    .peak_low_i     (peak_low_i),
    .vout_high_i    (vout_high_i),
    .peak_over_i    (peak_over_i),
    .vout_low_i     (vout_low_i),
    .mode_pfm_o     (mode_pfm_o),
    .hs_req_o       (hs_req_o),
    .ilim_reduced_o (ilim_reduced_o)
);

// File: tb/bmode_sel_tb_top.sv
module bmode_sel_tb_top;

    localparam int QUAL = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] force_v = 2'b00;
    logic       valley = 1'b0;
    logic       plow = 1'b0;
    logic       vhigh = 1'b0;
    logic       pover = 1'b0;
    logic       vlow = 1'b0;
    logic       mode_pfm;
    logic       hs_req;
    logic       ilim;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bmode_sel #(.QUAL_CYCLES(QUAL)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .force_i        (force_v),
        .valley_neg_i   (valley),
        .peak_low_i     (plow),
        .vout_high_i    (vhigh),
        .peak_over_i    (pover),
        .vout_low_i     (vlow),
        .mode_pfm_o     (mode_pfm),
        .hs_req_o       (hs_req),
        .ilim_reduced_o (ilim)
    );

    // vector: {force[1:0], valley, plow, vhigh, pover, vlow, exp_mode, exp_hs, exp_lim}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        10'b10_00000_101,  // R1 R9 pin PFM, request waits one edge
        10'b10_00000_111,  // R6 output below threshold sets request
        10'b10_00000_111,  // R7 held
        10'b10_00010_101,  // R7 peak over limit releases
        10'b10_00000_111,  // R6 set again
        10'b10_00100_101,  // R7 output above threshold releases
        10'b10_00100_101,  // R6 stays off while above
        10'b10_00000_111,  // R6 set again
        10'b01_00000_000,  // R1 R8 pin PWM
        10'b01_10000_000,  // R1 light load ignored when pinned
        10'b11_10000_000,  // R4 change to auto restarts run
        10'b00_00001_000   // R1 auto stays PWM
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got mode/hs/lim=%b expected %b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        valley = 1'b0; plow = 1'b0; vhigh = 1'b0; pover = 1'b0; vlow = 1'b0;
    endtask

    always begin
        @(posedge clk);
        if (!done && $time > 1500000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", {mode_pfm, hs_req, ilim}, 3'b000);
        rst_n = 1'b1;
        step();
        check("R10 after reset", {mode_pfm, hs_req, ilim}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            force_v = VEC[i][9:8];
            valley  = VEC[i][7];
            plow    = VEC[i][6];
            vhigh   = VEC[i][5];
            pover   = VEC[i][4];
            vlow    = VEC[i][3];
            step();
            check($sformatf("R1/R6/R7/R8/R9 vector %0d", i), {mode_pfm, hs_req, ilim}, VEC[i][2:0]);
        end

        // R2: peak-low run enters after exactly QUAL edges
        idle_inputs();
        force_v = 2'b00;
        step();
        plow = 1'b1;
        for (int k = 0; k < QUAL - 1; k++) step();
        check("R2 not yet", {mode_pfm, hs_req, ilim}, 3'b000);
        step();
        check("R2 entry", {mode_pfm, hs_req, ilim}, 3'b100);
        plow = 1'b0;
        step();
        check("R6 auto request", {mode_pfm, hs_req, ilim}, 3'b110);

        // R5 with R8: heavy load exits PFM, request drops at the same edge
        vlow = 1'b1;
        step();
        check("R5 R8 exit", {mode_pfm, hs_req, ilim}, 3'b000);
        vlow = 1'b0;

        // R3: a one-edge gap clears the run
        valley = 1'b1;
        for (int k = 0; k < QUAL - 1; k++) step();
        valley = 1'b0;
        step();
        valley = 1'b1;
        for (int k = 0; k < QUAL - 1; k++) step();
        check("R3 gap restarts", {mode_pfm, hs_req, ilim}, 3'b000);
        step();
        check("R3 entry after fresh run", {mode_pfm, hs_req, ilim}, 3'b100);

        // leave PFM again
        valley = 1'b0;
        vlow = 1'b1;
        step();
        vlow = 1'b0;
        check("R5 exit", mode_pfm, 1'b0);

        // R4: switching between auto codes mid-run restarts the run
        plow = 1'b1;
        for (int k = 0; k < 20; k++) step();
        force_v = 2'b11;
        step();
        for (int k = 0; k < QUAL - 1; k++) step();
        check("R4 restart", {mode_pfm, hs_req, ilim}, 3'b000);
        step();
        check("R4 entry with code 11", {mode_pfm, hs_req, ilim}, 3'b100);

        // R10: reset in the middle of PFM
        idle_inputs();
        force_v = 2'b10;
        step();
        step();
        rst_n = 1'b0;
        #1;
        check("R10 async reset", {mode_pfm, hs_req, ilim}, 3'b000);
        force_v = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R10 post reset", {mode_pfm, hs_req, ilim}, 3'b000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule